// File: doc/BRIEF.md
# Power-Mode Controller Interrupt Status Register

This block holds the pending interrupt flags of a power-mode controller. Four events from the controller can each latch a flag:
- an attempted write of an unusable mode configuration;
- a request for a mode change that is not allowed;
- a hardware-forced entry into safe mode;
- the end of a mode transition.

Each flag stays pending until software writes a one to its bit. The block drives the four flags as a pending vector and as one combined interrupt line. It does no masking; that is left to the logic downstream.

The controller delivers the three error and safe events as single-cycle pulses. It reports transitions as a busy level. Completion is taken from the falling edge of that level. It is not reported when the target mode is one of the two low-power modes (halt or stop). The register sits on a simple single-cycle strobe bus with a privilege code. Reads are always allowed. Writes count only at supervisor or test privilege.

Top module: `mode_irq_status`

## Requirements
- R1: After reset, all four flags, `pend`, `irq` and the read data of the register are zero.
- R2: Flag bit positions: bit 0 is transition done, bit 1 is safe-mode entry (`evt_safe_hw`), bit 2 is invalid mode request (`evt_mode_bad`), bit 3 is invalid configuration write (`evt_cfg_bad`). A pulse on an event input sets its flag, which is visible after the clock edge that samples the pulse.
- R3: A set flag stays set for any number of cycles until it is cleared by a write.
- R4: A write of 1 to a flag bit clears that flag. A write of 0 leaves the flag as it was.
- R5: The transition-done flag sets when `xfer_busy` goes from 1 to 0. It becomes visible after the first clock edge that samples `xfer_busy` low. The rising edge of `xfer_busy` and a steady `xfer_busy` do not set it.
- R6: The transition-done flag does not set when `tgt_mode` equals HALT_MODE (default 4'h8) or STOP_MODE (default 4'hA) in the cycle where the busy fall is seen.
- R7: A write with `bus_priv` = 2'b00 (user) has no effect. Codes 2'b01 (supervisor), 2'b10 and 2'b11 (test) may write.
- R8: When an event and a clearing write hit the same flag in the same cycle, the flag ends set.
- R9: Register bits 31..4 read as zero and ignore writes. An access with `bus_addr` other than REG_ADDR (default 8'h0C) neither reads the flags (its data is zero) nor changes them.
- R10: `irq` is a register equal to the OR of the four flags. It changes on the same edge as `pend`.
- R11: A read returns the current flags in the same cycle as the strobe and does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_cfg_bad | input | 1 | Pulse: invalid mode configuration was written |
| evt_mode_bad | input | 1 | Pulse: invalid mode transition was requested |
| evt_safe_hw | input | 1 | Pulse: hardware forced safe-mode entry |
| xfer_busy | input | 1 | Level: mode transition in progress |
| tgt_mode | input | MODE_W | Target mode of the current transition |
| bus_sel | input | 1 | Single-cycle access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | DATA_W | Write data |
| bus_priv | input | 2 | Privilege: 00 user, 01 supervisor, 1x test |
| bus_rdata | output | DATA_W | Read data, valid with the strobe |
| pend | output | 4 | Pending flag vector |
| irq | output | 1 | Combined interrupt |

## Verification
Each event pulse is tried alone and also with several pulses together. This shows that each input reaches only its own bit. Busy sequences are driven toward a normal target and toward each low-power target, with the flag sampled before and after the edge that follows the fall. This separates correct edge detection from level detection, from a fire one cycle too early, and from a missing suppression. Writes are tried with zero data, partial masks, user privilege, a wrong address, upper bits only, and a clear that collides with an event. Together these separate write-one-to-clear from plain write, from privilege leaks and from a priority that loses the event.

// File: rtl/mode_irq_status.sv
module mode_irq_status #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int MODE_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C,
  parameter logic [MODE_W-1:0] HALT_MODE = 4'h8,
  parameter logic [MODE_W-1:0] STOP_MODE = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_cfg_bad,
  input  logic              evt_mode_bad,
  input  logic              evt_safe_hw,
  input  logic              xfer_busy,
  input  logic [MODE_W-1:0] tgt_mode,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [1:0]        bus_priv,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [3:0]        pend,
  output logic              irq
);
  localparam int NFLAG = 4;
  localparam int PAD_W = DATA_W - NFLAG;

  logic [NFLAG-1:0] flags, set_vec, clr_vec, flag_nxt;
  logic busy_q;

  wire hit     = bus_sel && (bus_addr == REG_ADDR);
  wire wr_ok   = hit && bus_wr && (bus_priv != 2'b00);
  wire lowpow  = (tgt_mode == HALT_MODE) || (tgt_mode == STOP_MODE);
  wire busy_fall = busy_q && !xfer_busy;
  wire done_ev = busy_fall && !lowpow;

  assign set_vec  = {evt_cfg_bad, evt_mode_bad, evt_safe_hw, done_ev};
  assign clr_vec  = wr_ok ? bus_wdata[NFLAG-1:0] : '0;
  assign flag_nxt = (flags & ~clr_vec) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      busy_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      flags  <= flag_nxt;
      busy_q <= xfer_busy;
      irq    <= |flag_nxt;
    end
  end

  assign pend      = flags;
  assign bus_rdata = (hit && !bus_wr) ? {{PAD_W{1'b0}}, flags} : '0;

  p_cfg_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cfg_bad |=> pend[3]);
  p_mode_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_mode_bad |=> pend[2]);
  p_safe_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_safe_hw |=> pend[1]);
  p_done_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_fall && !lowpow) |=> pend[0]);
  p_lowpow_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_fall && lowpow && !pend[0]) |=> !pend[0]);
  p_user_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_priv == 2'b00) |=> ((pend & $past(pend)) == $past(pend)));
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> ((pend & $past(pend)) == $past(pend)));
  p_irq_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|pend));
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NFLAG] == '0);
endmodule

// File: tb/sim_mode_irq_status.sv
module sim_mode_irq_status;
  localparam int CLK_NS = 10;
  localparam logic [7:0] REG = 8'h0C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_cfg_bad = 0, evt_mode_bad = 0, evt_safe_hw = 0, xfer_busy = 0;
  logic [3:0] tgt_mode = 4'h1;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [1:0] bus_priv = 2'b01;
  logic [31:0] bus_rdata;
  logic [3:0] pend;
  logic irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  int req_q[$];

  mode_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .evt_cfg_bad(evt_cfg_bad), .evt_mode_bad(evt_mode_bad),
    .evt_safe_hw(evt_safe_hw), .xfer_busy(xfer_busy), .tgt_mode(tgt_mode),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_priv(bus_priv), .bus_rdata(bus_rdata), .pend(pend), .irq(irq));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int rq, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // scoreboard driver: read pushes the expected value
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input int rq);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(exp); req_q.push_back(rq);
    tick();
    bus_sel = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] p);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_priv = p;
    tick();
    bus_sel = 0; bus_wr = 0; bus_priv = 2'b01;
  endtask

  // monitor: pops and compares during each read strobe
  always @(negedge clk) begin
    if (bus_sel && !bus_wr) begin
      if (exp_q.size() == 0) chk(bus_rdata, 32'hx, 0, "unexpected read");
      else chk(bus_rdata, exp_q.pop_front(), req_q.pop_front(), "rdata");
    end
  end

  task automatic busy_seq(input logic [3:0] m);
    tgt_mode = m; xfer_busy = 1; tick(); tick();
    xfer_busy = 0; tick(); tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    chk(pend, 0, 1, "pend after reset");          // R1
    chk(irq, 0, 1, "irq after reset");            // R1
    rd(REG, 0, 1);                                // R1
    evt_cfg_bad = 1; tick(); evt_cfg_bad = 0;
    chk(pend, 4'h8, 2, "cfg flag");               // R2
    chk(irq, 1, 10, "irq with flag");             // R10
    rd(REG, 8, 11); rd(REG, 8, 11);               // R11
    repeat (5) tick();
    rd(REG, 8, 3);                                // R3
    wr(REG, 32'h0, 2'b01); rd(REG, 8, 4);         // R4
    wr(REG, 32'h8, 2'b01); rd(REG, 0, 4);         // R4
    chk(irq, 0, 10, "irq cleared");               // R10
    evt_mode_bad = 1; tick(); evt_mode_bad = 0;
    chk(pend, 4'h4, 2, "mode flag");              // R2
    evt_safe_hw = 1; tick(); evt_safe_hw = 0;
    chk(pend, 4'h6, 2, "safe flag");              // R2
    wr(REG, 32'h2, 2'b00); rd(REG, 6, 7);         // R7
    wr(REG, 32'h4, 2'b10); rd(REG, 2, 7);         // R7
    wr(REG, 32'h2, 2'b11); rd(REG, 0, 7);         // R7
    tgt_mode = 4'h1; xfer_busy = 1; tick(); tick(); tick();
    chk(pend, 0, 5, "busy rise/steady");          // R5
    xfer_busy = 0; #1;
    chk(pend, 0, 5, "before edge");               // R5
    tick();
    chk(pend, 1, 5, "done after fall");           // R5
    rd(REG, 1, 5);
    wr(REG, 32'h1, 2'b01);
    busy_seq(4'h8); chk(pend, 0, 6, "halt suppressed");   // R6
    busy_seq(4'hA); chk(pend, 0, 6, "stop suppressed");   // R6
    busy_seq(4'h9); chk(pend, 1, 6, "other mode sets");   // R6
    wr(REG, 32'h1, 2'b01);
    bus_sel = 1; bus_wr = 1; bus_addr = REG; bus_wdata = 32'h8; evt_cfg_bad = 1;
    tick();
    bus_sel = 0; bus_wr = 0; evt_cfg_bad = 0;
    chk(pend, 4'h8, 8, "set beats clear");        // R8
    wr(REG, 32'h8, 2'b01);
    evt_cfg_bad = 1; evt_mode_bad = 1; evt_safe_hw = 1; tick();
    evt_cfg_bad = 0; evt_mode_bad = 0; evt_safe_hw = 0;
    chk(pend, 4'hE, 2, "combined events");        // R2
    wr(REG, 32'hFFFF_FFF0, 2'b01); rd(REG, 32'hE, 9);  // R9
    wr(REG + 8'h4, 32'hF, 2'b01); rd(REG, 32'hE, 9);   // R9
    rd(REG + 8'h4, 0, 9);                              // R9
    wr(REG, 32'hE, 2'b01); rd(REG, 0, 4);
    chk(irq, 0, 10, "irq final");                 // R10
    tick();
    chk(exp_q.size(), 0, 11, "scoreboard drained");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule